// File: doc/BRIEF.md
# Indexed Panel Register Writer over SPI

This block is a small SPI master. It puts one 16-bit value into one register of a display panel controller, selected by an 8-bit index. A request gives the register number and the value. The block then runs two separate 24-bit frames on the serial bus, each with its own chip-select assertion. The index frame comes first and the data frame second. Each frame opens with a fixed lead byte: 0x74 for the index frame and 0x76 for the data frame. When both frames are out, the block pulses `done`. There is no serial input; the block drives only `sclk`, `mosi` and the active-low `cs_n`.

A typical use is panel bring-up. Writing 0x0000 to register 0x11 turns the panel on, and writing 0x0001 there shuts it down. Register 0x01 controls driver output. In that register, bit 13 picks normal rather than reversed display, bit 11 picks BGR order, bit 9 picks top-to-bottom scan and bit 8 picks left-to-right scan, and the other bits normally keep 0x2AEF. The block does not decode any of these values.

The serial clock comes from `clk` through a parameterised divider. `HALF_DIV` is the number of `clk` cycles in each half of an SCLK period. The default of 3 gives 100/6 ≈ 16.7 MHz from a 100 MHz clock, which stays under the 20 MHz limit of the panel bus. `GAP_HALVES` sets how many SCLK half-periods `cs_n` stays high between the two frames.

The controller is a Moore state machine with these states:
- IDLE waits for a request.
- SETUP holds `cs_n` low and `sclk` high while the first bit settles.
- LOW and HIGH are the two halves of each bit.
- HOLD keeps `cs_n` low after the last rising edge.
- GAP keeps `cs_n` high between the frames.
- FINISH lasts one cycle and raises `done`.

Its transitions are:
- IDLE→SETUP on an accepted request.
- SETUP→LOW, LOW→HIGH and HIGH→LOW when the divider expires.
- HIGH→HOLD after the 24th bit.
- HOLD→GAP after the index frame.
- GAP→SETUP into the data frame.
- HOLD→FINISH after the data frame.
- FINISH→IDLE.

Top module: `spw_panel_writer`

## Requirements
- R1: While reset is held and just after it, `cs_n`=1, `sclk`=1, `mosi`=1, `busy`=0 and `done`=0.
- R2: The bus uses SPI mode 3. `sclk` is high whenever `cs_n` is high, including the cycle in which `cs_n` falls, and the receiver samples `mosi` on the rising edges of `sclk`.
- R3: The first frame of a write carries, MSB first, the byte 0x74, then 0x00, then the 8-bit register number.
- R4: The second frame carries, MSB first, the byte 0x76, then the high byte of the value, then its low byte.
- R5: Each frame has its own low period of `cs_n` and contains exactly 24 rising edges of `sclk`. A write produces exactly two frames.
- R6: Between the two frames, `cs_n` stays high for GAP_HALVES×HALF_DIV `clk` cycles, and GAP_HALVES is at least 2, so the gap is never shorter than one SCLK period.
- R7: Every low phase of `sclk` lasts exactly HALF_DIV `clk` cycles. The default HALF_DIV=3 gives SCLK = clk/6.
- R8: `busy` rises in the cycle after a request is accepted and stays high up to and including the single cycle in which `done` is 1. While `done` is 1, `cs_n` is high. Both `busy` and `done` are 0 in the following cycle.
- R9: A `req_valid` that arrives while `busy` is high is ignored. The frames still carry the request that was accepted, and no extra write follows.
- R10: Within a frame, `mosi` changes only while `sclk` is low. It holds steady through each high phase.
- R11: `done` appears (100+GAP_HALVES)×HALF_DIV+1 `clk` edges after the edge that accepts the request, counting that edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request, taken when the block is idle |
| req_reg | input | 8 | Register number to write |
| req_value | input | 16 | Value to write |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out, MSB first |
| cs_n | output | 1 | Chip select, active low, one low period per frame |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse when a write has finished |

## Verification
The assertions assume that `req_valid`, `req_reg` and `req_value` are synchronous to `clk` and stable at the clock edge, and that the two parameters satisfy HALF_DIV≥1 and GAP_HALVES≥2. The stimulus keeps to these assumptions. It changes inputs only on the falling edge of `clk` and draws register numbers and values from a seeded `$urandom`. It also places stray requests only while a write is in progress, never in the same cycle as an acceptance.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int FRAME_BITS = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP,
        ST_FINISH
    } spw_state_e;

endpackage

// File: rtl/spw_phase_timer.sv
module spw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    assign expire = (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R7: a phase never runs past its programmed length
    assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit);

endmodule

// File: rtl/spw_frame_shifter.sv
module spw_frame_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb,
    output logic         last
);

    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     sh_q;
    logic [IDX_W-1:0] idx_q;

    assign msb  = sh_q[W-1];
    assign last = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_word;
            idx_q <= IDX_W'(W - 1);
        end else if (shift) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            idx_q <= idx_q - IDX_W'(1);
        end
    end

    // R5: never shift past the last bit of a frame
    assert_no_overshift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last);

endmodule

// File: rtl/spw_panel_writer.sv
module spw_panel_writer
    import spw_pkg::*;
#(
    parameter int          HALF_DIV   = 3,
    parameter int          GAP_HALVES = 2,
    parameter logic [7:0]  IDX_LEAD   = 8'h74,
    parameter logic [7:0]  DAT_LEAD   = 8'h76
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [7:0]  req_reg,
    input  logic [15:0] req_value,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n,
    output logic        busy,
    output logic        done
);

    localparam int GAP_CYC = GAP_HALVES * HALF_DIV;
    localparam int CNT_W   = $clog2(GAP_CYC + 1);

    spw_state_e state_q, state_nx;
    logic        second_q;
    logic [7:0]  reg_q;
    logic [15:0] val_q;

    logic             expire;
    logic             restart;
    logic [CNT_W-1:0] limit;
    logic             sh_load, sh_shift, sh_msb, sh_last;
    logic [FRAME_BITS-1:0] sh_word;
    logic             accept;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign restart = expire || (state_q == ST_IDLE) || (state_q == ST_FINISH);
    assign limit   = (state_q == ST_GAP) ? CNT_W'(GAP_CYC) : CNT_W'(HALF_DIV);

    spw_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .expire  (expire)
    );

    assign sh_load  = accept || ((state_q == ST_GAP) && expire);
    assign sh_word  = accept ? {IDX_LEAD, 8'h00, req_reg} : {DAT_LEAD, val_q};
    assign sh_shift = (state_q == ST_HIGH) && expire && !sh_last;

    spw_frame_shifter #(.W(FRAME_BITS)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (sh_word),
        .shift     (sh_shift),
        .msb       (sh_msb),
        .last      (sh_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_nx = ST_SETUP;
            ST_SETUP:  if (expire)    state_nx = ST_LOW;
            ST_LOW:    if (expire)    state_nx = ST_HIGH;
            ST_HIGH:   if (expire)    state_nx = sh_last ? ST_HOLD : ST_LOW;
            ST_HOLD:   if (expire)    state_nx = second_q ? ST_FINISH : ST_GAP;
            ST_GAP:    if (expire)    state_nx = ST_SETUP;
            ST_FINISH:                state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            second_q <= 1'b0;
            reg_q    <= '0;
            val_q    <= '0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                reg_q    <= req_reg;
                val_q    <= req_value;
                second_q <= 1'b0;
            end else if ((state_q == ST_GAP) && expire) begin
                second_q <= 1'b1;
            end
        end
    end

    // registered Moore outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b1;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            cs_n <= !(state_nx inside {ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD});
            sclk <= (state_nx != ST_LOW);
            busy <= (state_nx != ST_IDLE);
            done <= (state_nx == ST_FINISH);
        end
    end

    assign mosi = cs_n ? 1'b1 : sh_msb;

    // checker state: length of the current chip-select high gap within a write
    logic [15:0] gap_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            gap_cnt_q <= '0;
        else if (cs_n && busy) gap_cnt_q <= gap_cnt_q + 16'd1;
        else                   gap_cnt_q <= '0;
    end

    assert_idle_clock_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    assert_mosi_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(!cs_n && sclk)) |-> $stable(mosi));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_framing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && cs_n));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_gap_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && $past(busy)) |-> (gap_cnt_q >= 16'(2 * HALF_DIV)));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(reg_q) && $stable(val_q)));

endmodule

// File: tb/spw_panel_writer_tb_top.sv
module spw_panel_writer_tb_top;

    localparam int H = 3;
    localparam int G = 2;
    localparam int LAT = (100 + G) * H + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_reg = '0;
    logic [15:0] req_value = '0;
    logic        sclk, mosi, cs_n, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spw_panel_writer #(.HALF_DIV(H), .GAP_HALVES(G)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_reg   (req_reg),
        .req_value (req_value),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done)
    );

    function automatic logic [23:0] exp_idx(input logic [7:0] r);
        return {8'h74, 8'h00, r};
    endfunction

    function automatic logic [23:0] exp_dat(input logic [15:0] v);
        return {8'h76, v[15:8], v[7:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus monitor
    bit          mon_en = 1'b0;
    logic [23:0] acc = '0;
    int          nbits = 0;
    logic [23:0] fr_v [2];
    int          fr_n [2];
    int          nfr = 0;
    int          bad_half = 0, bad_mosi = 0, bad_csfall = 0;
    int          gap_cur = 0, gap_last = 0;
    logic        p_sclk = 1'b1, p_cs = 1'b1, p_mosi = 1'b1;
    int          low_run = 0;

    always @(posedge sclk) if (mon_en && !cs_n) begin
        acc = {acc[22:0], mosi};
        nbits++;
    end

    always @(posedge cs_n) if (mon_en) begin
        if (nfr < 2) begin
            fr_v[nfr] = acc;
            fr_n[nfr] = nbits;
        end
        nfr++;
        nbits = 0;
        acc = '0;
    end

    always @(negedge clk) if (mon_en) begin
        if (p_cs && !cs_n && !sclk) bad_csfall++;
        if (!sclk) low_run++;
        else begin
            if (low_run != 0 && low_run != H) bad_half++;
            low_run = 0;
        end
        if (!cs_n && sclk && p_sclk && !p_cs && mosi != p_mosi) bad_mosi++;
        if (cs_n && busy) gap_cur++;
        else begin
            if (gap_cur > 0 && !cs_n) gap_last = gap_cur;
            gap_cur = 0;
        end
        p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
    end

    task automatic clear_mon();
        nfr = 0; nbits = 0; acc = '0; gap_last = 0;
        bad_half = 0; bad_mosi = 0; bad_csfall = 0;
        fr_v[0] = '0; fr_v[1] = '0; fr_n[0] = 0; fr_n[1] = 0;
    endtask

    task automatic do_write(input logic [7:0] r, input logic [15:0] v, input bit stray);
        int n;
        bit busy_ok;
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_reg = r; req_value = v;
        @(posedge clk);
        n = 1;
        busy_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < LAT + 50) begin
            if (!busy) busy_ok = 1'b0;
            if (stray && n == 40) begin
                req_valid = 1'b1; req_reg = ~r; req_value = ~v;
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(n == LAT, "R11 done latency", n, LAT);
        chk(busy_ok && busy && cs_n, "R8 busy through write", {busy_ok, busy, cs_n}, 3'b111);
        @(negedge clk);
        chk(!done && !busy, "R8 done one cycle", {done, busy}, 0);
        repeat (2 * LAT / 3) @(negedge clk);
        chk(nfr == 2, "R5 frame count (R9 no extra write)", nfr, 2);
        chk(fr_n[0] == 24 && fr_n[1] == 24, "R5 bits per frame", fr_n[0] * 100 + fr_n[1], 2424);
        chk(fr_v[0] == exp_idx(r), "R3 index frame (R9 stray ignored)", fr_v[0], exp_idx(r));
        chk(fr_v[1] == exp_dat(v), "R4 data frame (R9 stray ignored)", fr_v[1], exp_dat(v));
        chk(gap_last == G * H, "R6 cs gap", gap_last, G * H);
        chk(bad_half == 0, "R7 sclk low phase", bad_half, 0);
        chk(bad_mosi == 0, "R10 mosi stable in high phase", bad_mosi, 0);
        chk(bad_csfall == 0, "R2 cs falls with sclk high", bad_csfall, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && mosi && !busy && !done, "R1 reset outputs",
            {cs_n, sclk, mosi, busy, done}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && sclk && mosi && !busy && !done, "R1 after reset release",
            {cs_n, sclk, mosi, busy, done}, 5'b11100);
        mon_en = 1'b1;

        do_write(8'h11, 16'h0000, 1'b0);   // panel on
        do_write(8'h01, 16'h2AEF, 1'b0);   // driver output control
        do_write(8'h11, 16'h0001, 1'b1);   // shutdown with stray request
        do_write(8'hFF, 16'hFFFF, 1'b0);
        do_write(8'h00, 16'h0000, 1'b1);
        do_write(8'h80, 16'h8001, 1'b0);
        for (int i = 0; i < 14; i++) begin
            logic [7:0]  rr;
            logic [15:0] vv;
            rr = 8'($urandom);
            vv = 16'($urandom);
            do_write(rr, vv, 1'($urandom));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule